// File: doc/BRIEF.md
# Power-Pulsed Digital Clock Controller

This block decides when the digital section of a front-end readout chip receives a clock and when its differential input receivers draw bias current. Between bunch trains every power-on request is low. The clocks are then held low and the receivers are unbiased, which keeps the idle power of the chip close to zero. A digital power-on request brings up the control receivers at once. The acquisition clock then starts on the first full clock pulse after the request has been seen during a low phase of the free-running clock.

Two clock outputs serve the chip's two modes. The acquisition clock is shared with every other chip on the board and runs whenever digital power is on and no readout is in progress. The readout clock is handed from chip to chip along a chain. A start-readout pulse arms this chip. The local serializer reports its last bit, and the chip then returns an end-readout pulse, which becomes the start-readout of the next chip. Every clock enable passes through a latch that is open only while the clock is low. A request can therefore arrive at any moment, but a gated clock only ever starts or stops on a whole pulse.

The two receivers that carry channel reset and event validation are biased only while both the analog and the digital power-on requests are high.

Top module: `pp_clock_ctrl`

## Requirements
- R1: While rst_ni is low, acq_clk_o, ro_clk_o, readout_busy_o and end_readout_o are all low.
- R2: When pwr_digital_i is high through a low phase of clk_i and no readout is busy, acq_clk_o follows clk_i from the next rising edge onward.
- R3: When an enable changes while clk_i is high, the gated clock keeps its level until clk_i falls, so no shortened pulse occurs.
- R4: bias_ctl_rx_o equals pwr_digital_i with no clock delay.
- R5: bias_evt_rx_o is high only when pwr_analog_i and pwr_digital_i are both high, with no clock delay.
- R6: If start_readout_i is high at a rising edge while pwr_digital_i is high, readout_busy_o rises after that edge. ro_clk_o pulses from the next rising edge onward. acq_clk_o stays low while the readout is busy.
- R7: If readout_last_i is high at a rising edge while busy, readout_busy_o falls and end_readout_o is high for exactly one cycle after that edge. ro_clk_o still pulses at that edge and stops after it. readout_last_i has no effect while the block is idle.
- R8: start_readout_i has no effect while pwr_digital_i is low.
- R9: If pwr_digital_i is low at a rising edge during a readout, readout_busy_o falls at that edge and no end_readout_o pulse is produced.
- R10: With every power-on input low, both gated clocks and both bias outputs are low once clk_i has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_analog_i | input | 1 | Analog power-on request |
| pwr_digital_i | input | 1 | Digital power-on request |
| start_readout_i | input | 1 | Readout token from the previous chip in the chain |
| readout_last_i | input | 1 | Local serializer has shifted its last bit |
| acq_clk_o | output | 1 | Gated acquisition/conversion clock |
| ro_clk_o | output | 1 | Gated readout clock |
| bias_ctl_rx_o | output | 1 | Bias enable for the clock and control receivers |
| bias_evt_rx_o | output | 1 | Bias enable for the channel-reset and event-validation receivers |
| end_readout_o | output | 1 | One-cycle token to the next chip in the chain |
| readout_busy_o | output | 1 | Readout in progress |

## Verification
On every rising edge, the assertions check three things. The two latched enables are never both set. The end-readout token is a single-cycle pulse that only follows a busy cycle. The busy flag only rises after a start token with power on, and it drops whenever digital power is removed. The bench scenarios have to show the behaviour inside a clock phase: that a gated clock stays high when its enable drops mid-pulse, that the first pulse after a request lands on the expected edge, and that the bias outputs follow their requests with no delay.

// File: rtl/pp_clock_ctrl.sv
module pp_clock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_analog_i,
  input  logic pwr_digital_i,
  input  logic start_readout_i,
  input  logic readout_last_i,
  output logic acq_clk_o,
  output logic ro_clk_o,
  output logic bias_ctl_rx_o,
  output logic bias_evt_rx_o,
  output logic end_readout_o,
  output logic readout_busy_o
);

  logic busy_q, end_q;
  logic acq_req, ro_req;
  logic acq_en_l, ro_en_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      end_q <= pwr_digital_i & busy_q & readout_last_i;
      if (!pwr_digital_i)
        busy_q <= 1'b0;
      else if (busy_q && readout_last_i)
        busy_q <= 1'b0;
      else if (start_readout_i)
        busy_q <= 1'b1;
    end
  end

  assign acq_req = pwr_digital_i & ~busy_q;
  assign ro_req  = pwr_digital_i & busy_q;

  always_latch begin
    if (!rst_ni) begin
      acq_en_l <= 1'b0;
      ro_en_l  <= 1'b0;
    end else if (!clk_i) begin
      acq_en_l <= acq_req;
      ro_en_l  <= ro_req;
    end
  end

  assign acq_clk_o      = clk_i & acq_en_l;
  assign ro_clk_o       = clk_i & ro_en_l;
  assign bias_ctl_rx_o  = pwr_digital_i;
  assign bias_evt_rx_o  = pwr_digital_i & pwr_analog_i;
  assign end_readout_o  = end_q;
  assign readout_busy_o = busy_q;

  assert_enables_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acq_en_l && ro_en_l));

  assert_end_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_readout_o |=> !end_readout_o);

  assert_end_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_readout_o) |-> $past(readout_busy_o));

  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(readout_busy_o) |-> ($past(start_readout_i) && $past(pwr_digital_i)));

  assert_power_drop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_digital_i |=> (!readout_busy_o && !end_readout_o));

endmodule

// File: tb/tb_pp_clock_ctrl.sv
`timescale 1ns/1ps
module tb_pp_clock_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_analog_i = 1'b0, pwr_digital_i = 1'b0;
  logic start_readout_i = 1'b0, readout_last_i = 1'b0;
  logic acq_clk_o, ro_clk_o, bias_ctl_rx_o, bias_evt_rx_o, end_readout_o, readout_busy_o;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pp_clock_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pwr_analog_i(pwr_analog_i), .pwr_digital_i(pwr_digital_i),
    .start_readout_i(start_readout_i), .readout_last_i(readout_last_i),
    .acq_clk_o(acq_clk_o), .ro_clk_o(ro_clk_o),
    .bias_ctl_rx_o(bias_ctl_rx_o), .bias_evt_rx_o(bias_evt_rx_o),
    .end_readout_o(end_readout_o), .readout_busy_o(readout_busy_o));

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // lands 1 ns into the high phase
  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    pwr_digital_i = 1'b1; start_readout_i = 1'b1; readout_last_i = 1'b1;
    repeat (3) tick();
    chk("R1 acq_clk", acq_clk_o, 1'b0);
    chk("R1 ro_clk", ro_clk_o, 1'b0);
    chk("R1 busy", readout_busy_o, 1'b0);
    chk("R1 end", end_readout_o, 1'b0);
    pwr_digital_i = 1'b0; start_readout_i = 1'b0; readout_last_i = 1'b0;
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_bias();
    pwr_analog_i = 1'b1; pwr_digital_i = 1'b0; #0.2;
    chk("R5 analog only", bias_evt_rx_o, 1'b0);
    chk("R4 ctl off", bias_ctl_rx_o, 1'b0);
    pwr_digital_i = 1'b1; #0.2;
    chk("R5 both on", bias_evt_rx_o, 1'b1);
    chk("R4 ctl on", bias_ctl_rx_o, 1'b1);
    pwr_analog_i = 1'b0; #0.2;
    chk("R5 digital only", bias_evt_rx_o, 1'b0);
    pwr_digital_i = 1'b0;
    tick();
  endtask

  task automatic t_acq_start_stop();
    pwr_digital_i = 1'b1;
    chk("R3 no start in high phase", acq_clk_o, 1'b0);
    tick();
    chk("R2 acq clock runs", acq_clk_o, 1'b1);
    #2;
    chk("R2 acq clock low phase", acq_clk_o, 1'b0);
    tick();
    chk("R2 acq clock again", acq_clk_o, 1'b1);
    pwr_digital_i = 1'b0;
    #0.5;
    chk("R3 pulse kept after drop", acq_clk_o, 1'b1);
    chk("R4 ctl follows", bias_ctl_rx_o, 1'b0);
    tick();
    chk("R10 acq clock off", acq_clk_o, 1'b0);
    chk("R10 ro clock off", ro_clk_o, 1'b0);
    chk("R10 evt bias off", bias_evt_rx_o, 1'b0);
  endtask

  task automatic t_readout();
    pwr_digital_i = 1'b1;
    readout_last_i = 1'b1;
    tick();
    chk("R7 last ignored when idle", readout_busy_o, 1'b0);
    readout_last_i = 1'b0;
    tick();
    chk("R7 no end when idle", end_readout_o, 1'b0);
    start_readout_i = 1'b1;
    tick();
    start_readout_i = 1'b0;
    chk("R6 busy set", readout_busy_o, 1'b1);
    chk("R6 ro clock not yet", ro_clk_o, 1'b0);
    tick();
    chk("R6 ro clock runs", ro_clk_o, 1'b1);
    chk("R6 acq clock held", acq_clk_o, 1'b0);
    tick();
    chk("R6 ro clock continues", ro_clk_o, 1'b1);
    readout_last_i = 1'b1;
    tick();
    readout_last_i = 1'b0;
    chk("R7 busy cleared", readout_busy_o, 1'b0);
    chk("R7 end token", end_readout_o, 1'b1);
    chk("R7 final ro pulse", ro_clk_o, 1'b1);
    tick();
    chk("R7 end one cycle", end_readout_o, 1'b0);
    chk("R7 ro clock stopped", ro_clk_o, 1'b0);
    chk("R2 acq clock resumes", acq_clk_o, 1'b1);
  endtask

  task automatic t_start_unpowered();
    pwr_digital_i = 1'b0;
    tick();
    start_readout_i = 1'b1;
    tick();
    start_readout_i = 1'b0;
    chk("R8 busy stays low", readout_busy_o, 1'b0);
    tick();
    chk("R8 ro clock stays low", ro_clk_o, 1'b0);
  endtask

  task automatic t_abort();
    pwr_digital_i = 1'b1;
    start_readout_i = 1'b1;
    tick();
    start_readout_i = 1'b0;
    tick();
    chk("R6 busy before abort", readout_busy_o, 1'b1);
    pwr_digital_i = 1'b0;
    readout_last_i = 1'b1;
    tick();
    readout_last_i = 1'b0;
    chk("R9 busy cleared", readout_busy_o, 1'b0);
    chk("R9 no end token", end_readout_o, 1'b0);
    tick();
    chk("R9 no end later", end_readout_o, 1'b0);
    chk("R10 ro clock off", ro_clk_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_bias();
    t_acq_start_stop();
    t_readout();
    t_start_unpowered();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule